// File: doc/BRIEF.md
# Burst Address Sequencer with Sleep

This block sits at the front of a synchronous pipelined burst memory controller and generates the address for each beat of a four-beat burst. When an access starts, it captures the starting address. The bits above the two least significant ones stay frozen for the whole burst. The bottom two bits then step through a wraparound sequence each time the active-low advance strobe is sampled low. The order of the sequence is either interleaved (the start value XORed with the beat number) or linear (the start value plus the beat number, modulo four). A mode input chooses between the two orders. Stepping works the same way for read bursts and write bursts.

An asynchronous sleep request is synchronized and then sequenced into a low-power state. Any burst still in flight when sleep begins is abandoned. While the block is entering, holding or leaving sleep, start strobes are refused and flagged as protocol errors. On wake, a recovery window of a configurable number of cycles must pass before a new access is accepted.

Top module: `burst_seq_sleep`

## Requirements
- R1: While the synchronous active-low reset is held, at the following edge `mem_addr` becomes 0, and `asleep`, `acc_en` and `proto_err` become 0.
- R2: An edge that samples `cs`=1 and `ads_n`=0 with the sleep sequencer idle starts an access. After that edge, `mem_addr` equals `addr_in` as sampled and `acc_en` is 1.
- R3: With `burst_ilv`=1, the low two bits of `mem_addr` equal the start value XOR the beat count. From starts 0,1,2,3 the orders are 0123, 1032, 2301 and 3210.
- R4: With `burst_ilv`=0, the low two bits equal the start value plus the beat count, modulo 4. From starts 0,1,2,3 the orders are 0123, 1230, 2301 and 3012.
- R5: The beat count advances only at an edge that samples `adv_n`=0 during an active burst, and otherwise holds. On an edge that starts an access, the beat count resets to 0 regardless of `adv_n`.
- R6: Bits above bit 1 of `mem_addr` stay unchanged throughout a burst. After four advances, the low bits wrap back to the start value.
- R7: After `sleep_req` rises, `acc_en` is 0 following the third edge, and `asleep` is 1 following the fourth edge.
- R8: A burst in flight when sleep is entered is abandoned. `acc_en` stays 0 after wake until a new access starts.
- R9: After `sleep_req` falls, `asleep` is 0 following the third edge. Start strobes are refused for the next REC_CYC edges, and the edge after that accepts one.
- R10: A start strobe sampled while the sequencer is not idle is ignored (`mem_addr` and `acc_en` unchanged), and `proto_err` is 1 for exactly the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| ads_n | input | 1 | Access start strobe, active low |
| adv_n | input | 1 | Burst advance strobe, active low |
| burst_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Starting address |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| mem_addr | output | ADDR_W | Current burst address |
| asleep | output | 1 | High while in the sleep state |
| acc_en | output | 1 | High while a burst is valid and the block is awake |
| proto_err | output | 1 | One-cycle pulse after a refused start strobe |

## Verification
The burst-order assertions assume that `burst_ilv` is held constant while a burst is running, because the address is decoded from it combinationally. The bench changes the mode only on the edge that starts a new access. The sleep timing properties assume that `sleep_req` stays at each level long enough to pass the synchronizer. The stimulus holds every request level for many more cycles than the entry or recovery sequence takes, and it always drives `sleep_req` away from the clock edge.

// File: rtl/burst_seq_sleep.sv
module burst_seq_sleep #(
  parameter int ADDR_W  = 20,
  parameter int REC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              ads_n,
  input  logic              adv_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sleep_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              asleep,
  output logic              acc_en,
  output logic              proto_err
);
  localparam int CW = $clog2(REC_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ENTER, ST_SLEEP, ST_EXIT} pst_t;

  pst_t              st;
  logic [1:0]        zz_sync;
  logic [CW-1:0]     rec_cnt;
  logic [ADDR_W-3:0] hi_q;
  logic [1:0]        lo0_q, beat_q, lo_now;
  logic              act_q;

  wire strobe    = cs & ~ads_n;
  wire acc_start = strobe && (st == ST_IDLE);
  wire zz        = zz_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) zz_sync <= '0;
    else        zz_sync <= {zz_sync[0], sleep_req};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rec_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (zz) st <= ST_ENTER;
        ST_ENTER: st <= ST_SLEEP;
        ST_SLEEP: if (!zz) begin
                    st      <= ST_EXIT;
                    rec_cnt <= CW'(REC_CYC - 1);
                  end
        default:  if (zz) st <= ST_ENTER;
                  else if (rec_cnt == '0) st <= ST_IDLE;
                  else rec_cnt <= rec_cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo0_q  <= '0;
      beat_q <= '0;
      act_q  <= 1'b0;
    end else if (acc_start) begin
      hi_q   <= addr_in[ADDR_W-1:2];
      lo0_q  <= addr_in[1:0];
      beat_q <= '0;
      act_q  <= 1'b1;
    end else begin
      if (st != ST_IDLE)     act_q  <= 1'b0;
      if (act_q && !adv_n)   beat_q <= beat_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= strobe && (st != ST_IDLE);
  end

  assign lo_now   = burst_ilv ? (lo0_q ^ beat_q) : (lo0_q + beat_q);
  assign mem_addr = {hi_q, lo_now};
  assign asleep   = (st == ST_SLEEP);
  assign acc_en   = act_q && (st == ST_IDLE);

  logic chk_ok;
  always_ff @(posedge clk) chk_ok <= rst_n;

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    ($past(act_q) && !$past(adv_n) && !$past(acc_start)) |-> beat_q == $past(beat_q) + 2'd1) // R5
    else $error("beat did not step");
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    ($past(adv_n) && !$past(acc_start)) |-> $stable(beat_q)) // R5
    else $error("beat moved without advance");
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    !$past(acc_start) |-> $stable(mem_addr[ADDR_W-1:2])) // R6
    else $error("upper address moved mid-burst");
  AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER) |=> asleep) // R7
    else $error("enter did not reach sleep");
  AST_NO_ACC_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !acc_en) // R8
    else $error("access enabled while asleep");
  AST_EXIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXIT && rec_cnt == '0 && !zz) |=> (st == ST_IDLE)) // R9
    else $error("recovery did not end");
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    proto_err |-> ($past(strobe) && !$past(acc_start))) // R10
    else $error("spurious protocol error");
endmodule

// File: tb/burst_seq_sleep_tb.sv
module burst_seq_sleep_tb;
  localparam int AW  = 20;
  localparam int REC = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, ads_n = 1'b1, adv_n = 1'b1;
  logic burst_ilv = 1'b1, sleep_req = 1'b0;
  logic [AW-1:0] addr_in = '0, mem_addr;
  logic asleep, acc_en, proto_err;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  burst_seq_sleep #(.ADDR_W(AW), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .ads_n(ads_n), .adv_n(adv_n),
    .burst_ilv(burst_ilv), .addr_in(addr_in), .sleep_req(sleep_req),
    .mem_addr(mem_addr), .asleep(asleep), .acc_en(acc_en), .proto_err(proto_err));

  // {mode, start, beat0..beat3}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 2'd0, 8'h1B}, {1'b1, 2'd1, 8'h4E}, {1'b1, 2'd2, 8'hB1}, {1'b1, 2'd3, 8'hE4},
    {1'b0, 2'd0, 8'h1B}, {1'b0, 2'd1, 8'h6C}, {1'b0, 2'd2, 8'hB1}, {1'b0, 2'd3, 8'hC6}};

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic start_acc(input logic mode, input logic [AW-1:0] a, input logic adv);
    burst_ilv = mode; cs = 1'b1; ads_n = 1'b0; addr_in = a; adv_n = adv;
    tick(1);
    cs = 1'b0; ads_n = 1'b1; adv_n = 1'b1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] base, hold;
    tick(3);
    chk("R1 addr", mem_addr, '0);
    chk("R1 flags", {asleep, acc_en, proto_err}, '0);
    rst_n = 1'b1;
    tick(1);

    foreach (VEC[i]) begin
      base = AW'(i * 4 * 37 + 5 * 4) | AW'(VEC[i][9:8]);
      start_acc(VEC[i][10], base, i[0]);           // R5: load wins over advance
      chk(VEC[i][10] ? "R2/R3 beat0" : "R2/R4 beat0", mem_addr, {base[AW-1:2], VEC[i][7:6]});
      chk("R2 acc_en", AW'(acc_en), AW'(1));
      adv_n = 1'b1;
      tick(1);
      chk("R5 hold", mem_addr, {base[AW-1:2], VEC[i][7:6]});
      for (int b = 1; b < 4; b++) begin
        adv_n = 1'b0;
        tick(1);
        chk(VEC[i][10] ? "R3 beat" : "R4 beat", mem_addr, {base[AW-1:2], VEC[i][7-2*b -: 2]});
      end
      tick(1);
      adv_n = 1'b1;
      chk("R6 wrap", mem_addr, base);
    end

    base = 20'hABCD2;
    start_acc(1'b0, base, 1'b1);
    adv_n = 1'b0;
    sleep_req = 1'b1;
    tick(2);
    adv_n = 1'b1;
    chk("R7 acc_en before", AW'(acc_en), AW'(1));
    tick(1);
    chk("R7 acc_en off", AW'(acc_en), '0);
    chk("R7 not yet asleep", AW'(asleep), '0);
    tick(1);
    chk("R7 asleep", AW'(asleep), AW'(1));
    hold = mem_addr;
    cs = 1'b1; ads_n = 1'b0; addr_in = 20'h12345;
    tick(1);
    cs = 1'b0; ads_n = 1'b1;
    chk("R10 err pulse", AW'(proto_err), AW'(1));
    chk("R10 addr kept", mem_addr, hold);
    tick(1);
    chk("R10 err one cycle", AW'(proto_err), '0);

    sleep_req = 1'b0;
    tick(2);
    chk("R9 still asleep", AW'(asleep), AW'(1));
    tick(1);
    chk("R9 awake", AW'(asleep), '0);
    tick(REC - 1);
    cs = 1'b1; ads_n = 1'b0; addr_in = 20'h0F0F1;
    tick(1);
    chk("R9 refused err", AW'(proto_err), AW'(1));
    chk("R8 abandoned", AW'(acc_en), '0);
    tick(1);
    cs = 1'b0; ads_n = 1'b1;
    chk("R9 accepted", mem_addr, 20'h0F0F1);
    chk("R9 acc_en", AW'(acc_en), AW'(1));
    chk("R9 no err", AW'(proto_err), '0);

    rst_n = 1'b0;
    tick(1);
    chk("R1 re-reset", {mem_addr[AW-1:3], asleep, acc_en, proto_err}, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule